// File: doc/BRIEF.md
# SPI Slave Front End with Hold

This block sits between the four pins of a serial peripheral slave and a downstream command engine that runs on a fast system clock. It oversamples chip select, serial clock, serial data in and an active-low hold pin through two-flop synchronisers and finds the serial clock edges in the synchronised samples. From these it issues one-cycle capture and launch strobes. It also presents the captured data bit, registers the outgoing bit and drives the enable of the tri-state serial output.

At each falling edge of chip select, the block reads the idle level of the serial clock to choose clock mode 0 (idle low) or mode 3 (idle high). Input bits are taken on rising clock edges and output bits change on falling clock edges. Transfers are most significant bit first, and the engine supplies the bits in that order. A hold pause freezes the bit sequence in place and floats the output. The pause can start or end only while the serial clock is low. Raising chip select aborts the frame. The system clock must run at least four times faster than the serial clock.

Top module: `spi_slave_frontend`

## Requirements
- R1: After reset, `sdo_oe` is 0, `bit_count` is 0 and no strobe fires. A select that is already low when reset is released does not open a frame: strobes stay low until the block sees chip select go from high to low.
- R2: Each high-to-low transition of chip select gives a one-cycle `frame_start` pulse and clears `bit_count`. It also latches `clk_idle_high` from the serial clock level at that moment: 0 means mode 0 and 1 means mode 3.
- R3: A rising serial clock edge inside an open frame that is not held gives a one-cycle `rx_strobe`. It updates `rx_bit` to the data-in level and increments `bit_count` by one, wrapping at its width.
- R4: A falling serial clock edge inside an open frame that is not held gives a one-cycle `tx_strobe` and loads `tx_bit` into `sdo`.
- R5: In mode 0, a `tx_strobe` is issued in the same cycle as `frame_start`, so the first bit is ready before the first rising edge. In mode 3, no strobe goes with `frame_start`.
- R6: Hold pin changes take effect only in cycles where the synchronised serial clock is low. Pulling hold low while the clock is high does not pause the frame until the clock falls. Releasing hold while the clock is high does not resume the frame until the clock falls.
- R7: While held, no strobe fires, `sdo_oe` is 0, and `bit_count` and `rx_bit` keep their values even if the serial clock toggles. After the release, the frame continues from the same bit.
- R8: Chip select high ends the frame: `bit_count` returns to 0, `sdo_oe` goes to 0, any hold is cleared, and no strobe fires until the next select falling edge.
- R9: `sdo_oe` is 1 exactly when a frame is open, not held and `tx_req` is 1. It is registered, so a change of `tx_req` shows one cycle later.
- R10: A pin change reaches the registered outputs on the third rising system clock edge after it: two synchroniser stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| sdi_pin | input | 1 | Serial data in pin |
| hold_n_pin | input | 1 | Hold pin, active low |
| tx_bit | input | 1 | Next output bit from the engine |
| tx_req | input | 1 | Engine request to drive the output |
| rx_strobe | output | 1 | One-cycle pulse: a bit was captured |
| rx_bit | output | 1 | Last captured data bit |
| tx_strobe | output | 1 | One-cycle pulse: a bit was launched |
| sdo | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output driver enable (0 = high impedance) |
| frame_start | output | 1 | One-cycle pulse at select falling edge |
| clk_idle_high | output | 1 | Latched mode: 1 = mode 3, 0 = mode 0 |
| bit_count | output | CNT_W | Bits captured in the current frame |

## Verification
The assertions assume that every pin stays stable for at least two system clocks between changes, so each serial clock level and each select edge is seen at least once after synchronisation. They also assume that `tx_req` and `tx_bit` come from logic in the system clock domain. The stimulus changes pins only on falling system clock edges. It holds every serial clock level for four system clocks and changes data in and hold two cycles before the clock edge that follows. This also lets a behavioural model, which has its own two-sample delay, predict every output cycle by cycle.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  typedef enum logic {
    SPI_MODE0 = 1'b0,
    SPI_MODE3 = 1'b1
  } spi_mode_e;

  typedef struct packed {
    logic cs_n;
    logic sck;
    logic sdi;
    logic hold_n;
  } pin_bus_t;

  localparam int PIN_COUNT = $bits(pin_bus_t);
  // Reset image of the synchronisers: select reads as low so that a pin
  // already low at reset release never looks like a falling edge.
  localparam pin_bus_t PIN_RESET = '{cs_n: 1'b0, sck: 1'b0, sdi: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sfe_frame.sv
module sfe_frame
  import sfe_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      s_cs_n,
  input  logic      s_sck,
  output logic      sel,
  output logic      cs_fall,
  output logic      sck_rise,
  output logic      sck_fall,
  output logic      armed_q,
  output logic      armed_nxt,
  output spi_mode_e mode_q
);
  logic prev_cs_n;
  logic prev_sck;

  assign sel      = ~s_cs_n;
  assign cs_fall  = prev_cs_n & ~s_cs_n;
  assign sck_rise = ~prev_sck & s_sck;
  assign sck_fall = prev_sck & ~s_sck;

  always_comb begin
    armed_nxt = armed_q;
    if (!sel) armed_nxt = 1'b0;
    else if (cs_fall) armed_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cs_n <= 1'b0;
      prev_sck  <= 1'b0;
      armed_q   <= 1'b0;
      mode_q    <= SPI_MODE0;
    end else begin
      prev_cs_n <= s_cs_n;
      prev_sck  <= s_sck;
      armed_q   <= armed_nxt;
      if (cs_fall) mode_q <= spi_mode_e'(s_sck);
    end
  end

  // A frame can be open only while select has been low since its last fall
  assert_open_needs_select_R8: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> $past(sel));
endmodule

// File: rtl/sfe_hold.sv
module sfe_hold (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic cs_fall,
  input  logic armed_q,
  input  logic s_sck,
  input  logic s_hold_n,
  output logic hold_q,
  output logic hold_nxt
);
  always_comb begin
    hold_nxt = hold_q;
    if (!sel || cs_fall) hold_nxt = 1'b0;
    else if (armed_q && !s_sck) hold_nxt = ~s_hold_n;
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else hold_q <= hold_nxt;
  end

  // Hold state moves only while the clock is low, or on a select edge
  assert_hold_moves_sck_low_R6: assert property (@(posedge clk) disable iff (rst)
    (hold_q != $past(hold_q)) |-> (!$past(s_sck) || !$past(sel) || $past(cs_fall)));
endmodule

// File: rtl/spi_slave_frontend.sv
module spi_slave_frontend
  import sfe_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n_pin,
  input  logic             sck_pin,
  input  logic             sdi_pin,
  input  logic             hold_n_pin,
  input  logic             tx_bit,
  input  logic             tx_req,
  output logic             rx_strobe,
  output logic             rx_bit,
  output logic             tx_strobe,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             frame_start,
  output logic             clk_idle_high,
  output logic [CNT_W-1:0] bit_count
);
  pin_bus_t  raw_pins, s_pins;
  logic      sel, cs_fall, sck_rise, sck_fall;
  logic      armed_q, armed_nxt, hold_q, hold_nxt;
  logic      do_capture, do_launch;
  spi_mode_e mode_q;

  assign raw_pins = '{cs_n: cs_n_pin, sck: sck_pin, sdi: sdi_pin, hold_n: hold_n_pin};

  sfe_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RESET)) u_sync (
    .clk(clk), .rst(rst), .d(raw_pins), .q(s_pins)
  );

  sfe_frame u_frame (
    .clk(clk), .rst(rst), .s_cs_n(s_pins.cs_n), .s_sck(s_pins.sck),
    .sel(sel), .cs_fall(cs_fall), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .armed_q(armed_q), .armed_nxt(armed_nxt), .mode_q(mode_q)
  );

  sfe_hold u_hold (
    .clk(clk), .rst(rst), .sel(sel), .cs_fall(cs_fall), .armed_q(armed_q),
    .s_sck(s_pins.sck), .s_hold_n(s_pins.hold_n), .hold_q(hold_q), .hold_nxt(hold_nxt)
  );

  assign do_capture = armed_q & sel & ~hold_q & sck_rise;
  // Mode 0 has no leading falling edge, so the first launch rides on the select edge
  assign do_launch  = (armed_q & sel & ~hold_q & sck_fall) | (cs_fall & ~s_pins.sck);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_strobe   <= 1'b0;
      rx_bit      <= 1'b0;
      tx_strobe   <= 1'b0;
      sdo         <= 1'b0;
      sdo_oe      <= 1'b0;
      frame_start <= 1'b0;
      bit_count   <= '0;
    end else begin
      rx_strobe   <= do_capture;
      tx_strobe   <= do_launch;
      frame_start <= cs_fall;
      sdo_oe      <= armed_nxt & ~hold_nxt & tx_req;
      if (do_capture) rx_bit <= s_pins.sdi;
      if (do_launch) sdo <= tx_bit;
      if (!sel || cs_fall) bit_count <= '0;
      else if (do_capture) bit_count <= bit_count + CNT_W'(1);
    end
  end

  assign clk_idle_high = (mode_q == SPI_MODE3);

  assert_no_strobe_unarmed_R1: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> !rx_strobe);
  assert_start_clears_count_R2: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (bit_count == '0));
  assert_count_frozen_held_R7: assert property (@(posedge clk) disable iff (rst)
    (hold_q && $past(hold_q)) |-> ($stable(bit_count) && !rx_strobe));
  assert_deselect_clears_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(sel) |-> (bit_count == '0 && !sdo_oe));
  assert_oe_needs_open_R9: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> (armed_q && !hold_q));
endmodule

// File: tb/test_spi_slave_frontend.sv
module test_spi_slave_frontend;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n_pin = 1'b0, sck_pin = 1'b0, sdi_pin = 1'b0, hold_n_pin = 1'b1;
  logic tx_bit = 1'b0, tx_req = 1'b1;
  logic rx_strobe, rx_bit, tx_strobe, sdo, sdo_oe, frame_start, clk_idle_high;
  logic [CNT_W-1:0] bit_count;

  int errors = 0, checks = 0, n_rx = 0, start_tx = 0;
  logic [7:0] rx_byte = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_slave_frontend #(.CNT_W(CNT_W)) i_spi_slave_frontend (
    .clk(clk), .rst(rst), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin), .sdi_pin(sdi_pin),
    .hold_n_pin(hold_n_pin), .tx_bit(tx_bit), .tx_req(tx_req), .rx_strobe(rx_strobe),
    .rx_bit(rx_bit), .tx_strobe(tx_strobe), .sdo(sdo), .sdo_oe(sdo_oe),
    .frame_start(frame_start), .clk_idle_high(clk_idle_high), .bit_count(bit_count)
  );

  // Behavioural reference: pins seen two samples late, frame/hold bookkeeping
  int m_cs[3], m_ck[3], m_di[2], m_hn[2];
  int m_open = 0, m_hold = 0, m_rx = 0, m_tx = 0, m_rxbit = 0, m_sdo = 0;
  int m_oe = 0, m_start = 0, m_mode = 0, m_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cs = '{0, 0, 0}; m_ck = '{0, 0, 0}; m_di = '{0, 0}; m_hn = '{1, 1};
      m_open = 0; m_hold = 0; m_rx = 0; m_tx = 0; m_rxbit = 0; m_sdo = 0;
      m_oe = 0; m_start = 0; m_mode = 0; m_cnt = 0;
    end else begin
      int selected, opened, ck_up, ck_dn;
      selected = (m_cs[1] == 0);
      opened   = (m_cs[2] == 1) && selected;
      ck_up    = (m_ck[2] == 0) && (m_ck[1] == 1);
      ck_dn    = (m_ck[2] == 1) && (m_ck[1] == 0);
      m_rx    = m_open && selected && !m_hold && ck_up;
      m_tx    = (m_open && selected && !m_hold && ck_dn) || (opened && m_ck[1] == 0);
      m_start = opened;
      if (m_rx) begin m_rxbit = m_di[1]; m_cnt = (m_cnt + 1) % (1 << CNT_W); end
      if (m_tx) m_sdo = int'(tx_bit);
      if (!selected || opened) begin m_hold = 0; m_cnt = 0; end
      else if (m_open && m_ck[1] == 0) m_hold = (m_hn[1] == 0);
      if (opened) m_mode = m_ck[1];
      if (!selected) m_open = 0; else if (opened) m_open = 1;
      m_oe = m_open && !m_hold && tx_req;
      m_cs[2] = m_cs[1]; m_cs[1] = m_cs[0]; m_cs[0] = int'(cs_n_pin);
      m_ck[2] = m_ck[1]; m_ck[1] = m_ck[0]; m_ck[0] = int'(sck_pin);
      m_di[1] = m_di[0]; m_di[0] = int'(sdi_pin);
      m_hn[1] = m_hn[0]; m_hn[0] = int'(hold_n_pin);
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the reference, plus monitors
  always @(negedge clk) begin
    if (!rst) begin
      check("R3", "rx_strobe", int'(rx_strobe), m_rx);
      check("R3", "rx_bit", int'(rx_bit), m_rxbit);
      check("R4", "tx_strobe", int'(tx_strobe), m_tx);
      check("R4", "sdo", int'(sdo), m_sdo);
      check("R9", "sdo_oe", int'(sdo_oe), m_oe);
      check("R2", "frame_start", int'(frame_start), m_start);
      check("R2", "clk_idle_high", int'(clk_idle_high), m_mode);
      check("R7", "bit_count", int'(bit_count), m_cnt);
      if (rx_strobe) begin n_rx++; rx_byte = {rx_byte[6:0], rx_bit}; end
      if (frame_start && tx_strobe) start_tx++;
      if (tx_strobe) tx_bit = ~tx_bit;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits_m0(logic [7:0] b, int first, int last);
    for (int i = first; i >= last; i--) begin
      sdi_pin = b[i]; tick(2); sck_pin = 1'b1; tick(4); sck_pin = 1'b0; tick(2);
    end
  endtask

  task automatic send_byte_m3(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sck_pin = 1'b0; sdi_pin = b[i]; tick(4); sck_pin = 1'b1; tick(4);
    end
  endtask

  initial begin
    // R1: select already low during reset
    tick(5); rst = 1'b0; tick(1);
    check("R1", "oe after reset", int'(sdo_oe), 0);
    check("R1", "count after reset", int'(bit_count), 0);
    repeat (3) begin sck_pin = 1'b1; tick(4); sck_pin = 1'b0; tick(4); end
    check("R1", "no capture before select edge", n_rx, 0);
    check("R1", "no start before select edge", int'(frame_start), 0);

    // R10 latency and R2/R5 mode 0 frame
    cs_n_pin = 1'b1; tick(6);
    cs_n_pin = 1'b0; tick(2);
    check("R10", "start not before third edge", int'(frame_start), 0);
    tick(1);
    check("R10", "start on third edge", int'(frame_start), 1);
    check("R5", "mode 0 launch with start", int'(tx_strobe), 1);
    check("R2", "mode 0 latched", int'(clk_idle_high), 0);
    tick(2);
    send_bits_m0(8'hA5, 7, 0); tick(4);
    check("R3", "mode 0 byte", int'(rx_byte), 8'hA5);
    check("R3", "count after byte", int'(bit_count), 8);

    // R7 hold in mid byte
    send_bits_m0(8'h3C, 7, 5); tick(2);
    hold_n_pin = 1'b0; tick(5);
    check("R7", "oe low while held", int'(sdo_oe), 0);
    check("R7", "count kept at hold", int'(bit_count), 11);
    sdi_pin = 1'b1;
    repeat (4) begin sck_pin = 1'b1; tick(4); sck_pin = 1'b0; tick(4); end
    check("R7", "count frozen with clock toggling", int'(bit_count), 11);
    check("R7", "no captures while held", n_rx, 11);
    hold_n_pin = 1'b1; tick(5);
    check("R7", "oe back after release", int'(sdo_oe), 1);
    send_bits_m0(8'h3C, 4, 0); tick(4);
    check("R7", "byte intact across hold", int'(rx_byte), 8'h3C);

    // R6 hold only moves while clock low
    sck_pin = 1'b1; tick(2); hold_n_pin = 1'b0; tick(6);
    check("R6", "no hold with clock high", int'(sdo_oe), 1);
    sck_pin = 1'b0; tick(5);
    check("R6", "hold once clock low", int'(sdo_oe), 0);
    sck_pin = 1'b1; tick(2); hold_n_pin = 1'b1; tick(6);
    check("R6", "still held with clock high", int'(sdo_oe), 0);
    sck_pin = 1'b0; tick(5);
    check("R6", "released once clock low", int'(sdo_oe), 1);

    // R9 output request
    tx_req = 1'b0; tick(1);
    check("R9", "oe follows request low", int'(sdo_oe), 0);
    tx_req = 1'b1; tick(1);
    check("R9", "oe follows request high", int'(sdo_oe), 1);

    // R8 abort
    send_bits_m0(8'hF0, 7, 5);
    cs_n_pin = 1'b1; tick(4);
    check("R8", "count cleared by deselect", int'(bit_count), 0);
    check("R8", "oe off by deselect", int'(sdo_oe), 0);
    sck_pin = 1'b1; tick(4); sck_pin = 1'b0; tick(4);
    check("R8", "no capture after deselect", int'(rx_strobe), 0);

    // R2/R5 mode 3 frame
    sck_pin = 1'b1; tick(4);
    start_tx = 0;
    cs_n_pin = 1'b0; tick(4);
    check("R2", "mode 3 latched", int'(clk_idle_high), 1);
    check("R5", "no launch with start in mode 3", start_tx, 0);
    send_byte_m3(8'h96); tick(4);
    check("R3", "mode 3 byte", int'(rx_byte), 8'h96);
    cs_n_pin = 1'b1; tick(6);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule